// File: doc/BRIEF.md
# Panel Window and Orientation Command Sequencer

This block prepares a small colour display panel to receive a burst of pixels. A host presents a rectangular update region (first and last column, first and last row), a two-bit rotation code and a blue/red swap flag, then pulses `start`. The block first checks the request against the panel limits. If the request is legal, it emits a short stream of command and data bytes over a valid/ready byte port. `out_is_data` marks each byte as a command opcode (0) or a parameter byte (1).

The stream may begin with the orientation command, if the orientation setting has changed. It then carries the column range, the row range and the memory-write opcode. After the memory-write opcode is taken, a ready-for-pixels flag tells the host that the pixel stream may begin. The native panel is 176 columns by 220 rows. A rotation that swaps rows and columns also swaps those limits. A request that breaks the limits raises an error flag and produces no bytes.

Top module: `lcd_window_setup`

## Requirements
- R1: After reset, `out_valid`, `pix_ready` and `err` are all low.
- R2: A legal request emits the column-range command byte 0x2A, followed by four data bytes: 0x00, first column, 0x00, last column.
- R3: The row-range command byte 0x2B comes right after the column range, followed by four data bytes: 0x00, first row, 0x00, last row.
- R4: The last byte of every sequence is the memory-write command byte 0x2C, with no data bytes after it.
- R5: The orientation command byte 0x36 carries one data byte.
  - Bit 7 is row mirror, bit 6 is column mirror, bit 5 is row/column swap and bit 3 is the blue/red swap flag. All other bits are zero.
  - Rotation code 0 (0°) sets none of the three. Code 1 (90°) sets bits 7 and 5. Code 2 (180°) sets bits 7 and 6. Code 3 (270°) sets bits 6 and 5.
- R6: The orientation command and its data byte lead the sequence only when no orientation has been sent since reset, or when the requested data byte differs from the last one sent. Otherwise the sequence starts with 0x2A.
- R7: Checking a request against the limits:
  - With the swap bit clear, the limits are column ≤ 175 and row ≤ 219. With it set, they are column ≤ 219 and row ≤ 175.
  - A request whose first value exceeds its last, or whose end exceeds a limit, sets `err` from the cycle after `start`, emits nothing, and leaves the remembered orientation unchanged.
  - A legal request clears `err`.
- R8: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_is_data` hold steady and `out_valid` stays high.
- R9: `pix_ready` rises in the cycle after the memory-write byte is accepted. It clears in the cycle after the next accepted `start`.
- R10: A `start` pulse while a sequence is being emitted is ignored. This includes the cycle in which the memory-write byte is accepted. The sequence in progress is unchanged, and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| xs | input | 8 | First column |
| xe | input | 8 | Last column |
| ys | input | 8 | First row |
| ye | input | 8 | Last row |
| rot | input | 2 | Rotation code: 0=0°, 1=90°, 2=180°, 3=270° |
| bgr | input | 1 | Blue/red swap flag |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts byte |
| out_byte | output | 8 | Command or data byte |
| out_is_data | output | 1 | 1 = data byte, 0 = command byte |
| pix_ready | output | 1 | Panel is ready for the pixel burst |
| err | output | 1 | Last request was rejected |

## Verification
A new `start` can arrive in the same cycle as a byte handshake. The sharpest case is the cycle in which the memory-write byte is accepted and `pix_ready` is about to rise. The bench provokes this by raising `start` together with `out_ready` at chosen byte positions, including the final one, while the request inputs change to different values. It then judges that the byte stream matches the model for the original request, that `pix_ready` rises and stays high, and that no further bytes appear.

// File: rtl/lcd_window_setup.sv
module lcd_window_setup #(
  parameter int CW        = 8,
  parameter int COLS      = 176,
  parameter int ROWS      = 220,
  parameter logic [7:0] OP_ORIENT = 8'h36,
  parameter logic [7:0] OP_COLS   = 8'h2A,
  parameter logic [7:0] OP_ROWS   = 8'h2B,
  parameter logic [7:0] OP_WRITE  = 8'h2C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] xs,
  input  logic [CW-1:0] xe,
  input  logic [CW-1:0] ys,
  input  logic [CW-1:0] ye,
  input  logic [1:0]    rot,
  input  logic          bgr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_byte,
  output logic          out_is_data,
  output logic          pix_ready,
  output logic          err
);
  localparam logic [CW-1:0] LIM_N = CW'(COLS - 1);
  localparam logic [CW-1:0] LIM_S = CW'(ROWS - 1);
  localparam int SW = 4;
  localparam logic [SW-1:0] ST_FIRST = '0;
  localparam logic [SW-1:0] ST_COLS  = SW'(2);
  localparam logic [SW-1:0] ST_LAST  = SW'(12);

  logic          busy;
  logic [SW-1:0] step;
  logic [CW-1:0] xs_q, xe_q, ys_q, ye_q;
  logic [7:0]    mad_q, mad_last;
  logic          mad_known;

  wire swap = rot[0];
  wire mir_row = rot[0] ^ rot[1];
  wire mir_col = rot[1];
  wire [7:0] mad_new = {mir_row, mir_col, swap, 1'b0, bgr, 3'b000};

  wire [CW-1:0] xlim = swap ? LIM_S : LIM_N;
  wire [CW-1:0] ylim = swap ? LIM_N : LIM_S;
  wire bad = (xs > xe) || (ys > ye) || (xe > xlim) || (ye > ylim);

  wire accept = start && !busy;
  wire fire   = out_valid && out_ready;
  wire send_orient = !mad_known || (mad_new != mad_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= ST_FIRST;
      err       <= 1'b0;
      pix_ready <= 1'b0;
      mad_known <= 1'b0;
      mad_last  <= '0;
      mad_q     <= '0;
      xs_q      <= '0;
      xe_q      <= '0;
      ys_q      <= '0;
      ye_q      <= '0;
    end else if (accept) begin
      err       <= bad;
      pix_ready <= 1'b0;
      if (!bad) begin
        busy      <= 1'b1;
        step      <= send_orient ? ST_FIRST : ST_COLS;
        mad_q     <= mad_new;
        mad_last  <= mad_new;
        mad_known <= 1'b1;
        xs_q      <= xs;
        xe_q      <= xe;
        ys_q      <= ys;
        ye_q      <= ye;
      end
    end else if (fire) begin
      if (step == ST_LAST) begin
        busy      <= 1'b0;
        pix_ready <= 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assign out_valid = busy;

  always_comb begin
    out_byte    = 8'h00;
    out_is_data = 1'b1;
    case (step)
      4'd0:  begin out_byte = OP_ORIENT; out_is_data = 1'b0; end
      4'd1:  out_byte = mad_q;
      4'd2:  begin out_byte = OP_COLS;   out_is_data = 1'b0; end
      4'd4:  out_byte = 8'(xs_q);
      4'd6:  out_byte = 8'(xe_q);
      4'd7:  begin out_byte = OP_ROWS;   out_is_data = 1'b0; end
      4'd9:  out_byte = 8'(ys_q);
      4'd11: out_byte = 8'(ye_q);
      4'd12: begin out_byte = OP_WRITE;  out_is_data = 1'b0; end
      default: out_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/lcd_window_setup_chk.sv
module lcd_window_setup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_is_data,
  input logic       pix_ready,
  input logic       err
);
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_data)));

  a_r9_pix_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_is_data && out_byte == 8'h2C) |=> pix_ready);

  a_r9_no_pix_while_streaming: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !out_valid);

  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);

  a_r6_stream_opens_with_command: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !out_is_data);
endmodule

bind lcd_window_setup lcd_window_setup_chk u_chk (.*);

// File: tb/sim_lcd_window_setup.sv
module sim_lcd_window_setup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] xs = '0, xe = '0, ys = '0, ye = '0;
  logic [1:0] rot = '0;
  logic bgr = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, out_is_data, pix_ready, err;
  logic [7:0] out_byte;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [7:0] m_last = '0;
  bit m_known = 0;
  logic [7:0] eb [16];
  bit ed [16];
  int en;

  always #10 clk = ~clk;

  lcd_window_setup u0 (.clk(clk), .rst_n(rst_n), .start(start), .xs(xs), .xe(xe),
    .ys(ys), .ye(ye), .rot(rot), .bgr(bgr), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_is_data(out_is_data),
    .pix_ready(pix_ready), .err(err));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mad(input logic [1:0] r, input logic b);
    logic [7:0] v;
    case (r)
      2'd0: v = 8'h00;
      2'd1: v = 8'hA0;
      2'd2: v = 8'hC0;
      default: v = 8'h60;
    endcase
    return v | (b ? 8'h08 : 8'h00);
  endfunction

  function automatic bit exp_bad(input int a, input int b, input int c, input int d,
                                 input logic [1:0] r);
    int xl, yl;
    xl = (r == 2'd1 || r == 2'd3) ? 219 : 175;
    yl = (r == 2'd1 || r == 2'd3) ? 175 : 219;
    return (a > b) || (c > d) || (b > xl) || (d > yl);
  endfunction

  task automatic push(input logic [7:0] v, input bit d);
    eb[en] = v; ed[en] = d; en = en + 1;
  endtask

  task automatic request(input int a, input int b, input int c, input int d,
                         input logic [1:0] r, input logic g, input int intr_at,
                         input int stall_pct);
    bit bad;
    logic [7:0] mv;
    int got;
    logic [7:0] pb;
    bit pd, pv, done;
    bad = exp_bad(a, b, c, d, r);
    mv = exp_mad(r, g);
    en = 0;
    if (!bad) begin
      if (!m_known || mv != m_last) begin push(8'h36, 0); push(mv, 1); end
      push(8'h2A, 0); push(8'h00, 1); push(8'(a), 1); push(8'h00, 1); push(8'(b), 1);
      push(8'h2B, 0); push(8'h00, 1); push(8'(c), 1); push(8'h00, 1); push(8'(d), 1);
      push(8'h2C, 0);
      m_known = 1; m_last = mv;
    end
    @(negedge clk);
    xs = 8'(a); xe = 8'(b); ys = 8'(c); ye = 8'(d); rot = r; bgr = g;
    start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(err == bad, "R7 err flag", err, bad);
    chk(pix_ready == 1'b0, "R9 pix_ready cleared by start", pix_ready, 0);
    if (bad) begin
      for (int i = 0; i < 6; i++) begin
        chk(!out_valid, "R7 no bytes on rejected request", out_valid, 0);
        @(negedge clk);
      end
      chk(!pix_ready, "R7 pix_ready stays low", pix_ready, 0);
      return;
    end
    got = 0; pv = 0; pb = '0; pd = 0; done = 0;
    for (int t = 0; t < 400 && !done; t++) begin
      if (pv) begin
        chk(out_valid && out_byte == pb && out_is_data == pd, "R8 held while stalled",
            out_byte, pb);
      end
      start = 1'b0;
      out_ready = (($urandom % 100) >= stall_pct);
      if (out_valid && out_ready) begin
        if (got < 16) begin
          chk(got < en && out_byte == eb[got] && out_is_data == ed[got],
              (got == en - 1) ? "R4 memory-write byte" :
              (eb[got] == 8'h36 || got == 1 && ed[0] == 0 && eb[0] == 8'h36) ?
                "R5 R6 orientation byte" : "R2 R3 window byte",
              {out_is_data, out_byte}, {ed[got], eb[got]});
        end
        if (got == intr_at) begin
          start = 1'b1;
          xs = 8'd3; xe = 8'd1; ys = 8'd9; ye = 8'd200; rot = ~r; bgr = ~g;
        end
        got = got + 1;
        if (got == en) done = 1;
        pv = 0;
      end else begin
        pv = out_valid;
        pb = out_byte;
        pd = out_is_data;
      end
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(got == en, "R4 byte count", got, en);
    chk(pix_ready == 1'b1, "R9 pix_ready after memory-write", pix_ready, 1);
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid && pix_ready, "R10 no second sequence", out_valid, 0);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !pix_ready && !err, "R1 reset state",
        {out_valid, pix_ready, err}, 0);

    request(0, 175, 0, 219, 2'd0, 1'b0, -1, 0);
    request(0, 175, 0, 219, 2'd0, 1'b0, -1, 30);
    request(5, 219, 7, 175, 2'd1, 1'b1, -1, 50);
    request(0, 176, 0, 10, 2'd0, 1'b0, -1, 0);
    request(9, 8, 0, 10, 2'd1, 1'b1, -1, 0);
    request(0, 200, 0, 176, 2'd3, 1'b0, -1, 0);
    request(10, 20, 30, 40, 2'd2, 1'b0, -1, 0);
    request(0, 10, 0, 10, 2'd1, 1'b1, -1, 0);
    request(0, 0, 0, 0, 2'd3, 1'b0, 12, 20);
    request(1, 2, 3, 4, 2'd3, 1'b0, 10, 0);
    request(1, 2, 3, 4, 2'd0, 1'b1, 5, 40);

    for (int k = 0; k < 60; k++) begin
      logic [1:0] r;
      logic g;
      int xl, yl, a, b, c, d;
      r = (($urandom % 3) == 0) ? 2'($urandom) : rot;
      g = (($urandom % 3) == 0) ? 1'($urandom) : bgr;
      xl = r[0] ? 219 : 175;
      yl = r[0] ? 175 : 219;
      a = $urandom % (xl + 1);
      b = a + ($urandom % (xl - a + 1));
      c = $urandom % (yl + 1);
      d = c + ($urandom % (yl - c + 1));
      if (($urandom % 6) == 0) begin
        if ($urandom % 2) b = xl + 1 + ($urandom % (255 - xl)); else begin c = 0; d = 0; a = b + 1; end
        if (a > 255) a = 0;
      end
      request(a, b, c, d, r, g, (($urandom % 4) == 0) ? int'($urandom % 13) : -1,
              $urandom % 60);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule